// File: doc/BRIEF.md
# DMA Command-Queue Register Interface

This block is the register file that software uses to drive a DMA engine's host command queue. It sits on a simple 32-bit register bus made of an address, a write strobe, write data and read data. It holds the queue base, the queue end, a producer (write) pointer and a consumer (read) pointer, an interrupt enable register and an interrupt status register. It drives one level-sensitive interrupt line. All other words in the decoded window are plain storage.

The block does not move any data. A write to the producer pointer behaves as if the queued work finished at once. The consumer pointer takes the new producer value, and the two completion flags in the status register are set: one for the upstream direction and one for the downstream direction. If either matching enable bit is set, the interrupt line rises. Software can cancel that completion event for exactly one producer update. It does so by first writing a fixed key value to the consumer-pointer word. This lets the driver reposition the queue without taking a spurious interrupt.

Top module: `cmdq_regif`

## Requirements
- R1: After reset, every register reads 0 except interrupt status, which reads 0xF8000000. The interrupt output is low and the one-shot arm flag is clear.
- R2: The queue base word (byte offset 0x10) and every word in range that is not one of the special offsets 0x14, 0x18, 0x1C, 0x20 and 0x24 store and return all 32 bits written.
- R3: A write to the queue end word (0x14) keeps only the low 18 bits, so the stored value is the written value ANDed with 0x0003FFFF.
- R4: A write to the producer pointer (0x18) stores the value ANDed with 0x0003FFFF. The consumer pointer (0x1C) takes that same masked value on the same clock edge.
- R5: A bus write to the consumer pointer never changes its stored value. Any value other than 0xEE882266 has no effect at all.
- R6: Writing 0xEE882266 to 0x1C arms a one-shot flag. The next producer-pointer write clears the flag and leaves the status register and the interrupt unchanged. The write after that behaves normally again.
- R7: A producer-pointer write with the flag clear sets status bits 4 and 5. If interrupt-enable bit 4 or bit 5 is 1 at that moment, the interrupt output is high from the next cycle.
- R8: A write to the interrupt-enable word (0x20) stores the value ANDed with 0xBFEFF07F.
- R9: A status write (0x24) with bit 4 or bit 5 set clears both bits and lowers the interrupt. Status bits 31:6 and 3:0 are never changed by the write. A status write with neither bit set has no effect.
- R10: The interrupt output is a register. Changing the enable register neither raises nor lowers it.
- R11: Word indices at or beyond NUM_REGS read as 0, and writes to them are dropped. Address bits 1:0 are ignored, so only whole-word accesses exist.
- R12: Read data is registered. It shows the word addressed in one cycle at the output in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address inside the 4 KiB window |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq | output | 1 | Level interrupt, completion event |

## Verification
The hardest state to reach from the ports is the armed suppression together with the interrupt not being re-evaluated. The stimulus first writes the key to the consumer pointer and checks that the pointer still reads its old value. It then issues two producer writes with an enable bit set. The first must leave status and the interrupt untouched; the second must raise both. A separate sequence sets the completion flags while the enables are zero and then turns an enable on. It also turns the enable off while the line is high. In both cases the line must keep its previous level.

// File: rtl/cmdq_regif_pkg.sv
package cmdq_regif_pkg;

   // word indices whose behaviour is fixed by the queue protocol
   localparam int unsigned IDX_BASE = 4;
   localparam int unsigned IDX_END  = 5;
   localparam int unsigned IDX_PROD = 6;
   localparam int unsigned IDX_CONS = 7;
   localparam int unsigned IDX_ENA  = 8;
   localparam int unsigned IDX_STAT = 9;

   localparam logic [31:0] ENA_KEEP   = 32'hBFEF_F07F;
   localparam logic [31:0] ARM_KEY    = 32'hEE88_2266;
   localparam logic [31:0] STAT_INIT  = 32'hF800_0000;

   localparam int unsigned BIT_UP = 4;
   localparam int unsigned BIT_DN = 5;

   // words held by the queue logic rather than by plain storage
   function automatic logic is_queue_word(input int unsigned idx);
      return (idx >= IDX_END) && (idx <= IDX_STAT);
   endfunction

endpackage

// File: rtl/cmdq_regif_decode.sv
module cmdq_regif_decode #(
   parameter int ADDR_W   = 12,
   parameter int NUM_REGS = 32,
   localparam int IDX_W   = $clog2(NUM_REGS),
   localparam int WORD_AW = ADDR_W - 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);

   logic [WORD_AW-1:0] word;
   logic               unused_lo;

   assign word      = addr[ADDR_W-1:2];
   assign unused_lo = ^addr[1:0];
   assign hit       = int'(word) < NUM_REGS;
   assign idx       = word[IDX_W-1:0];

endmodule

// File: rtl/cmdq_regif_store.sv
module cmdq_regif_store #(
   parameter int NUM_REGS = 32,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [31:0]      wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [31:0]      rd_data
);

   logic [NUM_REGS*32-1:0] flat;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
      if (cmdq_regif_pkg::is_queue_word(g)) begin : g_hole
         assign flat[g*32 +: 32] = '0;
      end else begin : g_flop
         logic [31:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
               q <= wr_data;
         end
         assign flat[g*32 +: 32] = q;
      end
   end

   assign rd_data = flat[rd_idx*32 +: 32];

endmodule

// File: rtl/cmdq_regif_queue.sv
module cmdq_regif_queue #(
   parameter int NUM_REGS = 32,
   parameter int PTR_W    = 18,
   localparam int IDX_W   = $clog2(NUM_REGS),
   localparam logic [31:0] PTR_KEEP = (PTR_W >= 32) ? '1 : ((32'd1 << PTR_W) - 32'd1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_hit,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [31:0]      wr_data,
   output logic [31:0]      end_q,
   output logic [31:0]      prod_q,
   output logic [31:0]      cons_q,
   output logic [31:0]      ena_q,
   output logic [31:0]      stat_q,
   output logic             irq_q
);
   import cmdq_regif_pkg::*;

   logic wr_end, wr_prod, wr_cons, wr_ena, wr_stat;
   logic arm_q, ack_hit, ena_any;

   assign wr_end  = wr_en && wr_hit && (wr_idx == IDX_W'(IDX_END));
   assign wr_prod = wr_en && wr_hit && (wr_idx == IDX_W'(IDX_PROD));
   assign wr_cons = wr_en && wr_hit && (wr_idx == IDX_W'(IDX_CONS));
   assign wr_ena  = wr_en && wr_hit && (wr_idx == IDX_W'(IDX_ENA));
   assign wr_stat = wr_en && wr_hit && (wr_idx == IDX_W'(IDX_STAT));
   assign ack_hit = wr_data[BIT_UP] | wr_data[BIT_DN];
   assign ena_any = ena_q[BIT_UP] | ena_q[BIT_DN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         end_q  <= '0;
         prod_q <= '0;
         cons_q <= '0;
         ena_q  <= '0;
         stat_q <= STAT_INIT;
         arm_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (wr_end) end_q <= wr_data & PTR_KEEP;
         if (wr_ena) ena_q <= wr_data & ENA_KEEP;
         if (wr_prod) begin
            prod_q <= wr_data & PTR_KEEP;
            cons_q <= wr_data & PTR_KEEP;
            if (arm_q) begin
               arm_q <= 1'b0;
            end else begin
               stat_q[BIT_UP] <= 1'b1;
               stat_q[BIT_DN] <= 1'b1;
               if (ena_any) irq_q <= 1'b1;
            end
         end
         if (wr_cons && (wr_data == ARM_KEY)) arm_q <= 1'b1;
         if (wr_stat && ack_hit) begin
            stat_q[BIT_UP] <= 1'b0;
            stat_q[BIT_DN] <= 1'b0;
            irq_q          <= 1'b0;
         end
      end
   end

   // R4: producer update lands in the consumer word one edge later
   a_r4_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      wr_prod |=> (cons_q == ($past(wr_data) & PTR_KEEP)));
   // R5: bus writes never alter the consumer word
   a_r5_cons_keep: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cons |=> $stable(cons_q));
   // R6: armed producer write leaves status and line alone, disarms
   a_r6_suppress: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_prod && arm_q) |=> ($stable(stat_q) && $stable(irq_q) && !arm_q));
   // R7: unarmed producer write with an enable raises flags and line
   a_r7_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_prod && !arm_q && ena_any) |=> (irq_q && stat_q[BIT_UP] && stat_q[BIT_DN]));
   // R9: acknowledge clears both flags and the line, other bits kept
   a_r9_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && ack_hit) |=> (!irq_q && !stat_q[BIT_UP] && !stat_q[BIT_DN]
                                && (stat_q[31:6] == $past(stat_q[31:6]))
                                && (stat_q[3:0] == $past(stat_q[3:0]))));
   // R10: only an acknowledge can drop the line
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !(wr_stat && ack_hit)) |=> irq_q);

endmodule

// File: rtl/cmdq_regif.sv
module cmdq_regif #(
   parameter int ADDR_W   = 12,
   parameter int NUM_REGS = 32,
   parameter int PTR_W    = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   import cmdq_regif_pkg::*;

   localparam int IDX_W = $clog2(NUM_REGS);

   if (NUM_REGS <= int'(IDX_STAT)) begin : g_chk_regs
      $error("NUM_REGS must cover the status word");
   end
   if ((NUM_REGS * 4) > (2 ** ADDR_W)) begin : g_chk_addr
      $error("register file larger than the address window");
   end
   if ((PTR_W < 1) || (PTR_W > 32)) begin : g_chk_ptr
      $error("PTR_W must lie in 1..32");
   end

   logic             hit;
   logic [IDX_W-1:0] idx;
   logic [31:0]      store_rd, end_q, prod_q, cons_q, ena_q, stat_q, rd_word;

   cmdq_regif_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
      .addr (bus_addr),
      .hit  (hit),
      .idx  (idx)
   );

   cmdq_regif_store #(.NUM_REGS(NUM_REGS)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_we && hit),
      .wr_idx  (idx),
      .wr_data (bus_wdata),
      .rd_idx  (idx),
      .rd_data (store_rd)
   );

   cmdq_regif_queue #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_we),
      .wr_hit  (hit),
      .wr_idx  (idx),
      .wr_data (bus_wdata),
      .end_q   (end_q),
      .prod_q  (prod_q),
      .cons_q  (cons_q),
      .ena_q   (ena_q),
      .stat_q  (stat_q),
      .irq_q   (irq)
   );

   always_comb begin
      rd_word = '0;
      if (hit) begin
         case (int'(idx))
            IDX_END:  rd_word = end_q;
            IDX_PROD: rd_word = prod_q;
            IDX_CONS: rd_word = cons_q;
            IDX_ENA:  rd_word = ena_q;
            IDX_STAT: rd_word = stat_q;
            default:  rd_word = store_rd;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_word;
   end

   // R11: an address outside the register count reads back as zero
   a_r11_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> (bus_rdata == '0));
   // R12: the read port follows the address with one register
   a_r12_rd_stage: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && (int'(idx) == IDX_STAT)) |=> (bus_rdata[31:27] == 5'h1F));

endmodule

// File: tb/cmdq_regif_bench.sv
`timescale 1ns/1ps
module cmdq_regif_bench;
   localparam int ADDR_W = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_we = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              irq;

   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   logic  rd_issue = 1'b0;
   logic  rd_chk = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   cmdq_regif #(.ADDR_W(ADDR_W)) u_cmdq_regif (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // monitor: read data appears one edge after the address was presented
   always @(posedge clk) rd_chk <= rd_issue;
   always @(negedge clk) begin
      logic [31:0] e;
      string       t;
      if (rd_chk) begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_chk++;
         if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s: rdata=%h expected %h", t, bus_rdata, e);
         end
      end
   end

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
      bus_addr = a; bus_we = 1'b0; rd_issue = 1'b1;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      rd_issue = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      n_chk++;
      if (irq !== e) begin
         n_bad++;
         $display("FAIL %s: irq=%b expected %b", t, irq, e);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset image
      chk_irq(1'b0, "R1 irq after reset");
      rd(12'h000, 32'h0, "R1 word0");
      rd(12'h010, 32'h0, "R1 base");
      rd(12'h014, 32'h0, "R1 end");
      rd(12'h018, 32'h0, "R1 prod");
      rd(12'h01C, 32'h0, "R1 cons");
      rd(12'h020, 32'h0, "R1 enable");
      rd(12'h024, 32'hF800_0000, "R1 status");
      // R2 plain storage, R12 registered read
      wr(12'h010, 32'hDEAD_BEEF); rd(12'h010, 32'hDEAD_BEEF, "R2 base");
      wr(12'h040, 32'h1234_5678); rd(12'h040, 32'h1234_5678, "R2 word16");
      wr(12'h07C, 32'hA5A5_A5A5); rd(12'h07C, 32'hA5A5_A5A5, "R2 last word");
      rd(12'h010, 32'hDEAD_BEEF, "R12 back-to-back read 1");
      rd(12'h040, 32'h1234_5678, "R12 back-to-back read 2");
      // R11 out-of-range and byte lanes
      wr(12'h080, 32'hFFFF_FFFF); rd(12'h080, 32'h0, "R11 beyond count");
      rd(12'hFFC, 32'h0, "R11 window top");
      rd(12'h07C, 32'hA5A5_A5A5, "R11 no alias");
      rd(12'h042, 32'h1234_5678, "R11 low bits ignored");
      // R3 / R8 masks
      wr(12'h014, 32'hFFFF_FFFF); rd(12'h014, 32'h0003_FFFF, "R3 end mask");
      wr(12'h020, 32'hFFFF_FFFF); rd(12'h020, 32'hBFEF_F07F, "R8 enable mask");
      chk_irq(1'b0, "R10 enable write does not raise");
      wr(12'h020, 32'h0);
      // R4 / R7 producer write with enables off
      wr(12'h018, 32'hFFF1_2345);
      chk_irq(1'b0, "R7 no enable no line");
      rd(12'h018, 32'h0001_2345, "R4 prod mask");
      rd(12'h01C, 32'h0001_2345, "R4 cons mirror");
      rd(12'h024, 32'hF800_0030, "R7 flags set");
      wr(12'h020, 32'h0000_0010);
      chk_irq(1'b0, "R10 late enable does not raise");
      wr(12'h024, 32'h0000_0010); rd(12'h024, 32'hF800_0000, "R9 ack clears both");
      // R7 with enable on
      wr(12'h018, 32'h0000_0100);
      chk_irq(1'b1, "R7 line raised");
      rd(12'h024, 32'hF800_0030, "R7 flags with enable");
      wr(12'h020, 32'h0);
      chk_irq(1'b1, "R10 disable keeps line");
      wr(12'h024, 32'h0000_000F);
      chk_irq(1'b1, "R9 no-ack write ignored");
      rd(12'h024, 32'hF800_0030, "R9 no-ack status kept");
      wr(12'h024, 32'h0000_0020);
      chk_irq(1'b0, "R9 ack lowers line");
      rd(12'h024, 32'hF800_0000, "R9 upper bits kept");
      // R5 ordinary consumer write ignored
      wr(12'h01C, 32'h1234_5678); rd(12'h01C, 32'h0000_0100, "R5 cons unchanged");
      // R6 arm then suppress once
      wr(12'h020, 32'h0000_0020);
      wr(12'h01C, 32'hEE88_2266); rd(12'h01C, 32'h0000_0100, "R5 key not stored");
      wr(12'h018, 32'h0000_0200);
      chk_irq(1'b0, "R6 suppressed line");
      rd(12'h024, 32'hF800_0000, "R6 suppressed flags");
      rd(12'h01C, 32'h0000_0200, "R6 mirror still done");
      wr(12'h018, 32'h0000_0300);
      chk_irq(1'b1, "R6 one-shot expired");
      rd(12'h024, 32'hF800_0030, "R6 flags after expiry");
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog (all): state=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule